// File: doc/BRIEF.md
# Serial Flash Sequential Read Engine

This block sits between a processor's code-fetch port and a serial NOR flash device. Each fetch asks for a single byte through a valid/ready handshake with a 24-bit byte address. When no burst is open, the engine pulls chip-select low. It then shifts out the fast-read command 0x0B, the address and one dummy byte. After that it clocks in one data byte and hands it back with a single-cycle response strobe.

After a byte is delivered, the transaction stays open. The engine keeps the address that follows the delivered byte. If the next fetch asks for exactly that address, only eight more serial clocks are spent and no command is re-sent. Any other address closes chip-select and restarts with a full command sequence. A disable input stops new fetches from being accepted. A burst that is in flight when disable rises finishes its current byte and then closes cleanly.

The serial clock runs at half the system clock in SPI mode 0. The clock idles low, outgoing bits change on falling edges and incoming bits are sampled on rising edges.

Top module: `spi_fastread_ctrl`

## Requirements
- R1: Out of reset, chip-select is high, the serial clock is low, the response strobe is low, and a request is accepted (reqReady high) while the disable input is low.
- R2: Every new transaction drives chip-select low and sends command byte 0x0B as its first eight bits, most significant bit first.
- R3: The command is followed by the 24-bit request address, most significant bit first, and then eight dummy clocks. The first data bit is sampled on the 41st rising serial clock edge of the transaction.
- R4: The data byte is assembled most significant bit first and presented on rspData while rspValid is high for exactly one system cycle.
- R5: A request whose address equals the previously delivered address plus one (modulo 2^24, so 0xFFFFFF is followed by 0x000000) is served inside the open transaction. It uses exactly eight more rising serial edges, and chip-select stays low.
- R6: A request whose address is anything other than that closes chip-select. It is then served by a new transaction that carries the new address.
- R7: Between transactions, chip-select stays high for at least two system cycles, which is one full serial clock period.
- R8: The serial clock is low whenever chip-select is high. The data-out line never changes at a rising serial clock edge.
- R9: The data-out enable (spiMosiOe) is high for the command, address and dummy bits, and low during the data bits.
- R10: While disableIn is high, no request is accepted. A burst that is open when disable rises closes chip-select after its current byte is delivered. Chip-select stays high until a request is accepted after disable is cleared.
- R11: Only one request is outstanding at a time. reqReady is low from the acceptance cycle until the response has been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| disableIn | input | 1 | Disables the interface when high |
| reqValid | input | 1 | Fetch request valid |
| reqReady | output | 1 | Fetch request accepted on a cycle with reqValid high |
| reqAddr | input | 24 | Byte address of the fetch |
| rspValid | output | 1 | One-cycle strobe marking rspData valid |
| rspData | output | 8 | Fetched byte |
| spiCsN | output | 1 | Active-low flash chip-select |
| spiClk | output | 1 | Serial clock, system clock divided by two |
| spiMosi | output | 1 | Serial data to the flash |
| spiMosiOe | output | 1 | High while spiMosi carries meaningful bits |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
The assertions assume a requester that keeps reqValid and reqAddr steady until the request is accepted, and that issues no new request before the previous response has arrived. They also assume a flash that drives spiMiso only after falling serial clock edges. The bench requester waits for each response before raising reqValid again and changes its inputs only at falling system clock edges. The bench flash model updates its output only on falling serial clock edges. The random stimulus mixes strictly sequential addresses with arbitrary jumps, including a wrap past the top of the address space. Disable is toggled only in directed cases, with requests held pending while it is high.

// File: rtl/spi_fr_pkg.sv
package spi_fr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_RESP,
    ST_OPEN,
    ST_GAP
  } frState_t;

  // strobes from the sequencer to the shifting datapath
  typedef struct packed {
    logic loadCmd;   // open chip-select, load command/address/dummy
    logic loadData;  // arm eight data bits, release data-out
    logic step;      // advance one half of a serial clock period
    logic closeCs;   // raise chip-select
    logic takeAddr;  // capture the request address
    logic bumpAddr;  // advance the expected next address
  } frStrobes_t;

endpackage

// File: rtl/spi_fr_datapath.sv
module spi_fr_datapath
  import spi_fr_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int DUMMY_BITS = 8,
  parameter logic [7:0] CMD_BYTE = 8'h0B
) (
  input  logic              clk,
  input  logic              rstN,
  input  frStrobes_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              spiMiso,
  output logic              spiCsN,
  output logic              spiClk,
  output logic              spiMosi,
  output logic              spiMosiOe,
  output logic [DATA_W-1:0] rspData,
  output logic              bitDone,
  output logic              seqMatch
);

  localparam int HDR_W = 8 + ADDR_W + DUMMY_BITS;
  localparam int CNT_W = $clog2(HDR_W + 1);

  logic [HDR_W-1:0]  shiftOut;
  logic [DATA_W-1:0] shiftIn;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] addrSel;
  logic              csReg;
  logic              sclkReg;
  logic              oeReg;

  assign addrSel = strb.takeAddr ? reqAddr : nextAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextAddr <= '0;
    end else if (strb.takeAddr) begin
      nextAddr <= reqAddr;
    end else if (strb.bumpAddr) begin
      nextAddr <= nextAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csReg    <= 1'b1;
      sclkReg  <= 1'b0;
      oeReg    <= 1'b0;
      shiftOut <= '0;
      shiftIn  <= '0;
      bitCnt   <= '0;
    end else begin
      if (strb.loadCmd) begin
        csReg    <= 1'b0;
        sclkReg  <= 1'b0;
        oeReg    <= 1'b1;
        shiftOut <= {CMD_BYTE, addrSel, {DUMMY_BITS{1'b0}}};
        bitCnt   <= CNT_W'(HDR_W);
      end else if (strb.loadData) begin
        oeReg  <= 1'b0;
        bitCnt <= CNT_W'(DATA_W);
      end else if (strb.step) begin
        if (!sclkReg) begin
          sclkReg <= 1'b1;
          shiftIn <= {shiftIn[DATA_W-2:0], spiMiso};
        end else begin
          sclkReg  <= 1'b0;
          shiftOut <= {shiftOut[HDR_W-2:0], 1'b0};
          bitCnt   <= bitCnt - 1'b1;
        end
      end
      if (strb.closeCs) begin
        csReg   <= 1'b1;
        sclkReg <= 1'b0;
        oeReg   <= 1'b0;
      end
    end
  end

  assign spiCsN    = csReg;
  assign spiClk    = sclkReg;
  assign spiMosi   = shiftOut[HDR_W-1];
  assign spiMosiOe = oeReg;
  assign rspData   = shiftIn;
  assign bitDone   = (bitCnt == '0);
  assign seqMatch  = (reqAddr == nextAddr);

endmodule

// File: rtl/spi_fr_control.sv
module spi_fr_control
  import spi_fr_pkg::*;
#(
  parameter int GAP_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       disableIn,
  input  logic       reqValid,
  input  logic       bitDone,
  input  logic       seqMatch,
  output frStrobes_t strb,
  output logic       reqReady,
  output logic       rspValid
);

  localparam int GAP_W = $clog2(GAP_CYCLES + 1);

  frState_t   state, stateNext;
  logic       pending, pendingNext;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      gapCnt  <= '0;
    end else begin
      state   <= stateNext;
      pending <= pendingNext;
      if (strb.closeCs) begin
        gapCnt <= GAP_W'(GAP_CYCLES - 1);
      end else if (state == ST_GAP && gapCnt != '0) begin
        gapCnt <= gapCnt - 1'b1;
      end
    end
  end

  always_comb begin
    stateNext   = state;
    pendingNext = pending;
    strb        = '0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = !disableIn;
        if (reqValid && !disableIn) begin
          strb.takeAddr = 1'b1;
          strb.loadCmd  = 1'b1;
          stateNext     = ST_HDR;
        end
      end
      ST_HDR: begin
        if (bitDone) begin
          strb.loadData = 1'b1;
          stateNext     = ST_DATA;
        end else begin
          strb.step = 1'b1;
        end
      end
      ST_DATA: begin
        if (bitDone) begin
          stateNext = ST_RESP;
        end else begin
          strb.step = 1'b1;
        end
      end
      ST_RESP: begin
        rspValid      = 1'b1;
        strb.bumpAddr = 1'b1;
        stateNext     = ST_OPEN;
      end
      ST_OPEN: begin
        if (disableIn) begin
          strb.closeCs = 1'b1;
          pendingNext  = 1'b0;
          stateNext    = ST_GAP;
        end else begin
          reqReady = 1'b1;
          if (reqValid) begin
            strb.takeAddr = 1'b1;
            if (seqMatch) begin
              strb.loadData = 1'b1;
              stateNext     = ST_DATA;
            end else begin
              strb.closeCs = 1'b1;
              pendingNext  = 1'b1;
              stateNext    = ST_GAP;
            end
          end
        end
      end
      ST_GAP: begin
        if (gapCnt == '0) begin
          pendingNext = 1'b0;
          if (pending) begin
            strb.loadCmd = 1'b1;
            stateNext    = ST_HDR;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/spi_fastread_ctrl.sv
module spi_fastread_ctrl
  import spi_fr_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int DUMMY_BITS = 8,
  parameter int GAP_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              disableIn,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              spiCsN,
  output logic              spiClk,
  output logic              spiMosi,
  output logic              spiMosiOe,
  input  logic              spiMiso
);

  frStrobes_t strb;
  logic       bitDone;
  logic       seqMatch;

  spi_fr_control #(
    .GAP_CYCLES(GAP_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .disableIn (disableIn),
    .reqValid  (reqValid),
    .bitDone   (bitDone),
    .seqMatch  (seqMatch),
    .strb      (strb),
    .reqReady  (reqReady),
    .rspValid  (rspValid)
  );

  spi_fr_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DUMMY_BITS(DUMMY_BITS),
    .CMD_BYTE  (8'h0B)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .spiMiso   (spiMiso),
    .spiCsN    (spiCsN),
    .spiClk    (spiClk),
    .spiMosi   (spiMosi),
    .spiMosiOe (spiMosiOe),
    .rspData   (rspData),
    .bitDone   (bitDone),
    .seqMatch  (seqMatch)
  );

endmodule

// File: rtl/spi_fr_checker.sv
module spi_fr_checker (
  input logic clk,
  input logic rstN,
  input logic disableIn,
  input logic reqValid,
  input logic reqReady,
  input logic rspValid,
  input logic spiCsN,
  input logic spiClk,
  input logic spiMosi
);

  // R4: the response strobe lasts a single cycle
  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R5: a byte is handed back while the transaction is still open
  assert_rsp_in_burst_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !spiCsN);

  // R7: chip-select stays high for at least two system cycles
  assert_cs_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |=> spiCsN);

  // R8: serial clock idles low while deselected
  assert_clk_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiClk);

  // R8: data-out is steady across every rising serial edge
  assert_mosi_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && $rose(spiClk)) |-> $stable(spiMosi));

  // R10: a closed interface stays closed while disabled
  assert_disabled_closed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (disableIn && spiCsN && $past(disableIn) && $past(spiCsN)) |=> spiCsN);

  // R11: no second acceptance directly after one
  assert_single_outstanding_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind spi_fastread_ctrl spi_fr_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .disableIn (disableIn),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .spiCsN    (spiCsN),
  .spiClk    (spiClk),
  .spiMosi   (spiMosi)
);

// File: tb/tb_spi_fastread_ctrl.sv
module tb_spi_fastread_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        disableIn = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] reqAddr = '0;
  logic        rspValid;
  logic [7:0]  rspData;
  logic        spiCsN, spiClk, spiMosi, spiMosiOe;
  logic        spiMiso = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  spi_fastread_ctrl dut (
    .clk(clk), .rstN(rstN), .disableIn(disableIn),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspData(rspData),
    .spiCsN(spiCsN), .spiClk(spiClk), .spiMosi(spiMosi),
    .spiMosiOe(spiMosiOe), .spiMiso(spiMiso)
  );

  function automatic logic [7:0] flashByte(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model (mode 0) ----------------
  int          fBits = 0;
  logic [31:0] fHdr = '0;
  logic [7:0]  fOp = '0;
  logic [23:0] fAddr = '0;
  int          txnCount = 0;
  int          oeErr = 0;

  always @(posedge spiClk) begin
    if (!spiCsN) begin
      if (fBits < 32) fHdr = {fHdr[30:0], spiMosi};
      if (fBits < 40 && !spiMosiOe) oeErr++;
      if (fBits >= 40 && spiMosiOe) oeErr++;
      fBits++;
      if (fBits == 32) begin
        fOp   = fHdr[31:24];
        fAddr = fHdr[23:0];
      end
    end
  end

  always @(negedge spiClk) begin
    if (!spiCsN && fBits >= 40) begin
      int idx;
      logic [7:0] b;
      idx = fBits - 40;
      b = flashByte(fAddr + 24'(idx / 8));
      spiMiso = b[7 - (idx % 8)];
    end
  end

  always @(negedge spiCsN) begin
    fBits = 0;
    txnCount++;
  end

  always @(posedge spiCsN) begin
    if (fBits > 0) begin
      check(fOp == 8'h0B, "R2", "command byte", 32'(fOp), 32'h0B);
      check(fBits >= 48 && ((fBits - 40) % 8) == 0, "R5", "rising edges per transaction",
            32'(fBits), 32'(40 + 8 * ((fBits - 40) / 8)));
      fBits = 0;
    end
  end

  // ---------------- line monitors sampled between edges ----------------
  int   csHighRun = 0;
  int   gapErr = 0;
  int   clkIdleErr = 0;
  int   mosiErr = 0;
  logic prevClk = 1'b0;
  logic prevMosi = 1'b0;
  logic prevCs = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      if (spiCsN && spiClk) clkIdleErr++;
      if (!spiCsN && spiClk && !prevClk && spiMosi !== prevMosi) mosiErr++;
      if (prevCs && !spiCsN && csHighRun < 2) gapErr++;
      csHighRun = spiCsN ? csHighRun + 1 : 0;
    end
    prevClk  = spiClk;
    prevMosi = spiMosi;
    prevCs   = spiCsN;
  end

  // ---------------- requester and reference model ----------------
  bit          burstOpen = 0;
  logic [23:0] expNext = '0;
  int          txnExp = 0;

  task automatic issue(input logic [23:0] a);
    reqAddr  = a;
    reqValid = 1'b1;
    forever begin
      if (reqReady) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
  endtask

  task automatic waitRsp(output logic [7:0] d);
    while (!rspValid) @(negedge clk);
    d = rspData;
    @(negedge clk);
    check(!rspValid, "R4", "strobe width", 32'(rspValid), 0);
  endtask

  task automatic doRead(input logic [23:0] a, input string req);
    logic [7:0] d;
    bit seq;
    seq = burstOpen && (a == expNext);
    if (!seq) txnExp++;
    issue(a);
    waitRsp(d);
    check(d == flashByte(a), "R4", {req, " data"}, 32'(d), 32'(flashByte(a)));
    check(txnCount == txnExp, seq ? "R5" : "R6", {req, " transaction count"},
          32'(txnCount), 32'(txnExp));
    if (!seq) check(fAddr == a, "R3", {req, " address sent"}, 32'(fAddr), 32'(a));
    check(!spiCsN, "R5", "chip-select held after byte", 32'(spiCsN), 0);
    burstOpen = 1;
    expNext   = a + 24'd1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0]  d;
    logic [23:0] a;
    int          acc;
    void'($urandom(32'h5EED_0B0B));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(spiCsN == 1'b1, "R1", "chip-select after reset", 32'(spiCsN), 1);
    check(spiClk == 1'b0, "R1", "serial clock after reset", 32'(spiClk), 0);
    check(rspValid == 1'b0, "R1", "response after reset", 32'(rspValid), 0);
    check(reqReady == 1'b1, "R1", "ready after reset", 32'(reqReady), 1);

    // R2 R3 R4: single fetch
    doRead(24'h12_34_56, "single");
    // R5: sequential burst
    for (int i = 1; i < 6; i++) doRead(24'h12_34_56 + 24'(i), "burst");
    // R5: wrap at the top of the address space
    doRead(24'hFF_FFFE, "wrap start");
    doRead(24'hFF_FFFF, "wrap mid");
    doRead(24'h00_0000, "wrap end");
    // R6: backward jump and repeat of same address
    doRead(24'h00_0000, "repeat address");
    doRead(24'h80_0010, "jump");
    doRead(24'h80_000F, "backward");

    // R10: disable raised while a byte is in flight
    issue(expNext);
    disableIn = 1'b1;
    waitRsp(d);
    check(d == flashByte(expNext), "R10", "byte finished under disable", 32'(d),
          32'(flashByte(expNext)));
    repeat (4) @(negedge clk);
    check(spiCsN == 1'b1, "R10", "chip-select closed after disable", 32'(spiCsN), 1);
    burstOpen = 0;
    reqAddr  = 24'h00_0100;
    reqValid = 1'b1;
    acc = 0;
    for (int i = 0; i < 30; i++) begin
      if (reqReady || rspValid || !spiCsN) acc++;
      @(negedge clk);
    end
    check(acc == 0, "R10", "activity while disabled", 32'(acc), 0);
    reqValid  = 1'b0;
    disableIn = 1'b0;
    @(negedge clk);
    check(reqReady == 1'b1, "R10", "ready after enable", 32'(reqReady), 1);
    doRead(24'h00_0100, "after enable");

    // R11: ready stays low while a fetch is outstanding
    reqAddr  = 24'h00_0200;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    acc = 0;
    while (!rspValid) begin
      if (reqReady) acc++;
      @(negedge clk);
    end
    check(acc == 0, "R11", "ready while outstanding", 32'(acc), 0);
    check(rspData == flashByte(24'h00_0200), "R11", "outstanding data",
          32'(rspData), 32'(flashByte(24'h00_0200)));
    txnExp++;
    burstOpen = 1;
    expNext   = 24'h00_0201;
    @(negedge clk);

    // random mix of sequential runs and jumps
    for (int i = 0; i < 300; i++) begin
      if (burstOpen && ($urandom % 4) != 0) a = expNext;
      else a = 24'($urandom);
      doRead(a, "random");
      repeat ($urandom % 4) @(negedge clk);
    end

    repeat (10) @(negedge clk);
    check(oeErr == 0, "R9", "data-out enable phase errors", 32'(oeErr), 0);
    check(clkIdleErr == 0, "R8", "clock high while deselected", 32'(clkIdleErr), 0);
    check(mosiErr == 0, "R8", "data-out change at rising edge", 32'(mosiErr), 0);
    check(gapErr == 0, "R7", "short chip-select gap", 32'(gapErr), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule